// File: doc/BRIEF.md
# Heartbeat Collision Test Generator

After each transmission on the coaxial line ends, this block sends a short test burst on the collision-presence path. The burst tells the attached station that its collision signalling works. The block watches the transmit-data-valid input for the cycle in which it goes from active to inactive. It then counts a fixed idle delay and opens a window of fixed length. During that window the collision-on flag is high and a square-wave tone runs on the collision tone output.

The delay, the window length and the half-period of the tone are parameters in clock cycles. At a 100 MHz clock, the defaults give a 10 MHz tone that starts about 1.1 µs after the transmission ends and lasts about 1 µs. A strap input turns the whole function off. A new transmission aborts a heartbeat that has not yet finished. Merging this tone with any other collision tone, and all analog shaping, take place outside the block.

Top module: `hb_test_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no input activity, `cd_on` and `cd_tone` are both 0.
- R2: Call edge k the clock edge that samples `tx_valid`=0 while the previous sample was 1 and `hb_enable`=1. `cd_on` is first 1 after edge k+DELAY_CYC.
- R3: If nothing aborts it, `cd_on` stays 1 for exactly WINDOW_CYC consecutive cycles and is 0 after edge k+DELAY_CYC+WINDOW_CYC.
- R4: Any edge that samples `hb_enable`=0 leaves `cd_on` and `cd_tone` at 0 after that edge. This includes an edge during the delay or the window.
- R5: Any edge that samples `tx_valid`=1 aborts a pending or running heartbeat, so `cd_on` and `cd_tone` are 0 after that edge.
- R6: Each end of transmission gives at most one window. Idle cycles with `tx_valid` held at 0 never start another window.
- R7: In window cycle i, where i=0 is the first cycle with `cd_on`=1, `cd_tone` is 1 exactly when (i mod 2·TONE_HALF) < TONE_HALF. Outside the window `cd_tone` is 0.
- R8: An end of transmission sampled while `hb_enable`=0 produces no window, even if `hb_enable` is raised later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Transmit data valid, high during a transmission |
| hb_enable | input | 1 | Heartbeat strap, 1 enables the function |
| cd_on | output | 1 | High for the duration of the heartbeat window |
| cd_tone | output | 1 | Square-wave tone, gated to the window |

## Verification
Both outputs come from registers, so each result is due right after the clock edge that samples the stimulus. An abort takes effect one edge after `tx_valid` or a low `hb_enable` is sampled. The window opens DELAY_CYC edges after the edge that samples the fall and closes WINDOW_CYC edges after that. The bench drives inputs at the falling clock edge. It advances its own timing model at the rising edge and compares both outputs 1 ns later, on every cycle. In this way each due cycle is checked, together with every cycle before and after it.

// File: rtl/hb_pkg.sv
package hb_pkg;
   typedef enum logic [1:0] {
      HB_IDLE = 2'd0,
      HB_WAIT = 2'd1,
      HB_TONE = 2'd2
   } hb_state_e;
endpackage

// File: rtl/hb_edge_det.sv
module hb_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic fall
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig;
   end

   assign fall = sig_q & ~sig;

   // R6: a fall can only be reported after a cycle in which the signal was high
   p_fall_needs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> $past(sig));
endmodule

// File: rtl/hb_timer.sv
module hb_timer
   import hb_pkg::*;
#(
   parameter int DELAY_CYC  = 110,
   parameter int WINDOW_CYC = 100
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      abort,
   output hb_state_e state
);
   localparam int MAXC = (DELAY_CYC > WINDOW_CYC) ? DELAY_CYC : WINDOW_CYC;
   localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [CW-1:0] DLY_LD = CW'(DELAY_CYC - 1);
   localparam logic [CW-1:0] WIN_LD = CW'(WINDOW_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= HB_IDLE;
         cnt_q <= '0;
      end else if (abort) begin
         state <= HB_IDLE;
         cnt_q <= '0;
      end else if (start) begin
         state <= HB_WAIT;
         cnt_q <= DLY_LD;
      end else begin
         case (state)
            HB_WAIT: begin
               if (cnt_q == '0) begin
                  state <= HB_TONE;
                  cnt_q <= WIN_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            HB_TONE: begin
               if (cnt_q == '0) state <= HB_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: begin
               state <= HB_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   // R5/R4: an abort always leaves the timer idle
   p_abort_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (state == HB_IDLE));
   // R2: the window is only entered from the delay phase
   p_tone_from_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == HB_TONE && $past(state) != HB_TONE) |-> ($past(state) == HB_WAIT));
endmodule

// File: rtl/hb_tone_gen.sv
module hb_tone_gen #(
   parameter int TONE_HALF = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic tone
);
   generate
      if (TONE_HALF == 1) begin : g_toggle
         logic ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ph_q <= 1'b1;
            else if (!active) ph_q <= 1'b1;
            else              ph_q <= ~ph_q;
         end
         assign tone = active & ph_q;
      end else begin : g_count
         localparam int PER = 2 * TONE_HALF;
         localparam int TW  = $clog2(PER);
         localparam logic [TW-1:0] LAST = TW'(PER - 1);
         localparam logic [TW-1:0] HALF = TW'(TONE_HALF);
         logic [TW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ph_q <= '0;
            else if (!active)        ph_q <= '0;
            else if (ph_q == LAST)   ph_q <= '0;
            else                     ph_q <= ph_q + 1'b1;
         end
         assign tone = active & (ph_q < HALF);
      end
   endgenerate

   // R7: the first cycle of a window carries a high tone
   p_tone_first_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> tone);
endmodule

// File: rtl/hb_test_gen.sv
module hb_test_gen
   import hb_pkg::*;
#(
   parameter int DELAY_CYC  = 110,
   parameter int WINDOW_CYC = 100,
   parameter int TONE_HALF  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_valid,
   input  logic hb_enable,
   output logic cd_on,
   output logic cd_tone
);
   localparam int RW = $clog2(WINDOW_CYC + 1);

   generate
      if (DELAY_CYC < 1)  begin : g_bad_dly $error("DELAY_CYC must be at least 1"); end
      if (WINDOW_CYC < 1) begin : g_bad_win $error("WINDOW_CYC must be at least 1"); end
      if (TONE_HALF < 1)  begin : g_bad_half $error("TONE_HALF must be at least 1"); end
   endgenerate

   logic      fall;
   logic      abort;
   hb_state_e state;

   hb_edge_det u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   (tx_valid),
      .fall  (fall)
   );

   assign abort = tx_valid | ~hb_enable;

   hb_timer #(
      .DELAY_CYC  (DELAY_CYC),
      .WINDOW_CYC (WINDOW_CYC)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (fall),
      .abort (abort),
      .state (state)
   );

   assign cd_on = (state == HB_TONE);

   hb_tone_gen #(
      .TONE_HALF (TONE_HALF)
   ) u_tone (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (cd_on),
      .tone   (cd_tone)
   );

   // window length monitor for the assertions below
   logic [RW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (!cd_on) run_q <= '0;
      else             run_q <= run_q + 1'b1;
   end

   p_cancel_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> (!cd_on && !cd_tone));
   p_off_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hb_enable |=> (!cd_on && !cd_tone));
   p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cd_on |-> (run_q < RW'(WINDOW_CYC)));
   p_window_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cd_on) && !$past(tx_valid) && $past(hb_enable)) |-> (run_q == RW'(WINDOW_CYC)));
   p_tone_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cd_on) |-> !cd_tone);
endmodule

// File: tb/hb_test_gen_tb_top.sv
module hb_test_gen_tb_top;
   localparam int D = 110;
   localparam int W = 100;
   localparam int H = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_valid = 1'b0;
   logic hb_enable = 1'b1;
   logic cd_on, cd_tone;

   int checks = 0;
   int fails = 0;

   // bench timing model
   bit m_active = 0;
   int m_t = 0;
   bit m_txp = 0;

   always #2 clk = ~clk;

   hb_test_gen #(.DELAY_CYC(D), .WINDOW_CYC(W), .TONE_HALF(H)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .hb_enable(hb_enable),
      .cd_on(cd_on), .cd_tone(cd_tone)
   );

   function automatic bit exp_on();
      return m_active && (m_t >= D) && (m_t < D + W);
   endfunction

   function automatic bit exp_tone();
      return exp_on() && (((m_t - D) % (2 * H)) < H);
   endfunction

   task automatic model_edge(input bit tx, input bit en);
      if (!en || tx) m_active = 0;
      else if (m_txp && !tx) begin m_active = 1; m_t = 0; end
      else if (m_active) begin
         m_t++;
         if (m_t >= D + W) m_active = 0;
      end
      m_txp = tx;
   endtask

   task automatic check(input string tag);
      checks++;
      if (cd_on !== exp_on()) begin
         fails++;
         $display("FAIL %s cd_on actual=%0b expected=%0b t=%0d", tag, cd_on, exp_on(), m_t);
      end
      checks++;
      if (cd_tone !== exp_tone()) begin
         fails++;
         $display("FAIL %s cd_tone actual=%0b expected=%0b t=%0d", tag, cd_tone, exp_tone(), m_t);
      end
   endtask

   task automatic step(input bit tx, input bit en, input string tag);
      @(negedge clk);
      tx_valid = tx;
      hb_enable = en;
      @(posedge clk);
      model_edge(tx, en);
      #1;
      check(tag);
   endtask

   task automatic run(input bit tx, input bit en, input int n, input string tag);
      for (int i = 0; i < n; i++) step(tx, en, tag);
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      // R1: reset state
      repeat (3) @(posedge clk);
      #1; check("R1");
      @(negedge clk); rst_n = 1'b1;
      run(0, 1, 20, "R1");
      // R2, R3, R7: one full heartbeat
      run(1, 1, 30, "R2");
      run(0, 1, D + W + 20, "R3");
      // R6: long idle, no retrigger
      run(0, 1, 400, "R6");
      // R5: abort during delay
      run(1, 1, 10, "R5");
      run(0, 1, 50, "R5");
      run(1, 1, 5, "R5");
      run(0, 1, D + W + 10, "R5");
      // R5: abort during the window
      run(0, 1, D + 30, "R5");
      run(1, 1, 3, "R5");
      run(0, 1, D + W + 10, "R5");
      // R4: disable during delay and during window
      run(1, 1, 5, "R4");
      run(0, 1, 40, "R4");
      run(0, 0, 3, "R4");
      run(0, 1, D + W + 10, "R4");
      run(1, 1, 5, "R4");
      run(0, 1, D + 20, "R4");
      run(0, 0, 2, "R4");
      run(0, 1, D + W, "R4");
      // R8: fall while disabled, enable raised afterwards
      run(1, 0, 10, "R8");
      run(0, 0, 5, "R8");
      run(0, 1, D + W + 50, "R8");
      // R7: randomized frames and gaps
      for (int f = 0; f < 70; f++) begin
         int len, gap;
         bit en;
         len = 1 + ($urandom % 40);
         gap = $urandom % 300;
         en  = (($urandom % 8) != 0);
         run(1, en, len, "R7");
         if (($urandom % 5) == 0) begin
            run(0, 1, gap / 2, "R7");
            run(0, 0, 1 + ($urandom % 3), "R4");
            run(0, 1, gap / 2, "R7");
         end else begin
            run(0, en, gap, "R7");
         end
      end
      run(0, 1, D + W + 5, "R6");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule